// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block couples two 18-bit buses, called A and B, with one storage path per direction. Each path holds a single word. The word can pass straight through while the path's latch control is high. It can be loaded on a rising edge of the path's capture clock while that clock's enable is active (low). Otherwise it keeps its last value. Each path has its own output-enable, which is active low. The outputs appear as separate data and drive-enable signals, so a pad ring or a simulation-only tri-state wrapper can build the real bidirectional pins from them. The data passes through without inversion.

The block runs on a system clock. The per-direction capture clocks are sampled on that clock. A rising edge is seen when a sample is high and the sample before it was low. Each bus input has a keeper. Any bit whose drive-present flag is low reads back the last level that was driven on it, so an undriven wire never reaches the storage as an unknown value. The storage words have no reset. A user must load them through the latch control or a capture before relying on a held value.

Top module: `xcvrBridge`

## Requirements
- R1: The A-to-B path (inputs leAb, cpAb, ceAbN, oeAbN) and the B-to-A path (leBa, cpBa, ceBaN, oeBaN) work independently and follow identical rules, so operations on both paths in the same cycle do not interfere.
- R2: While a path's latch control is high, its output equals the source bus value of the current cycle, bit for bit and non-inverted, whatever the capture clock and its enable do.
- R3: While the latch control is low and the capture clock input stays at one level, the path output does not change, even if the source bus changes.
- R4: While the latch control is low and the clock enable is low, a capture clock sampled high after a low sample loads the source bus value of that cycle, and the path output shows it from the next cycle on.
- R5: While the latch control is low and the clock enable is high, rising capture clock samples are ignored and the output keeps its stored value.
- R6: The drive-enable output of a path is 1 exactly when its active-low output-enable is 0. While the path is released, its data output keeps showing the stored word, and re-enabling the path drives the same word again. Both buses driven at once counts as contention and is flagged.
- R7: When the latch control goes from high to low, the path holds the source value that was present in the last cycle the control was high.
- R8: A bus bit whose drive-present flag is 0 reads as the last value it had while driven. After reset the keepers read all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset for keepers and clock edge detectors |
| aIn | input | 18 | Level seen on the A bus pins |
| aDrv | input | 18 | Per-bit flag, 1 when an external driver is present on A |
| bIn | input | 18 | Level seen on the B bus pins |
| bDrv | input | 18 | Per-bit flag, 1 when an external driver is present on B |
| leAb | input | 1 | Latch control, A-to-B path (1 = pass through) |
| cpAb | input | 1 | Capture clock, A-to-B path |
| ceAbN | input | 1 | Active-low capture clock enable, A-to-B path |
| oeAbN | input | 1 | Active-low output enable onto B |
| leBa | input | 1 | Latch control, B-to-A path |
| cpBa | input | 1 | Capture clock, B-to-A path |
| ceBaN | input | 1 | Active-low capture clock enable, B-to-A path |
| oeBaN | input | 1 | Active-low output enable onto A |
| bOut | output | 18 | Word to drive onto B |
| bOutEn | output | 1 | Drive enable for B |
| aOut | output | 18 | Word to drive onto A |
| aOutEn | output | 1 | Drive enable for A |

## Verification
Four properties are checked on every clock for each path. Pass-through follows a fully driven source. A clock edge is held off while the enable is high. An enabled rising sample loads the word that is seen one cycle later. An undriven source under pass-through stays steady. On top of these, two buses driven at once is flagged. Other behaviour shows only in the bench's scenarios. These are the value kept after the latch control falls, the word kept across a release and re-enable, the keeper's value after reset, and the two paths working concurrently. The scenarios and a random run are compared with a reference model.

// File: rtl/xcvrPkg.sv
package xcvrPkg;
  // Strobes from one direction's control to its datapath
  typedef struct packed {
    logic passThru;  // storage transparent this cycle
    logic grab;      // qualified capture edge this cycle
    logic drive;     // destination bus driven
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvrBusKeeper.sv
module xcvrBusKeeper #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] padDrv,
  output logic [WIDTH-1:0] busVal
);
  logic [WIDTH-1:0] keepReg;

  // Per-bit resolution: a driven bit shows the pad, an undriven one the keeper
  for (genvar bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : gKeep
    always_comb begin
      busVal[bitIdx] = padDrv[bitIdx] ? padIn[bitIdx] : keepReg[bitIdx];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) keepReg[bitIdx] <= 1'b0;
      else       keepReg[bitIdx] <= busVal[bitIdx];
    end
  end
endmodule

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        latchEn,
  input  logic        clkIn,
  input  logic        clkEnN,
  input  logic        outEnN,
  output xcvrStrobe_t strobe
);
  logic clkPrev;
  logic clkRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkIn;
  end

  assign clkRise = clkIn & ~clkPrev;

  // Latch control wins over the edge path
  always_comb begin
    strobe.passThru = latchEn;
    strobe.grab     = ~latchEn & ~clkEnN & clkRise;
    strobe.drive    = ~outEnN;
  end
endmodule

// File: rtl/xcvrPath.sv
module xcvrPath
  import xcvrPkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] srcVal,
  input  xcvrStrobe_t      strobe,
  output logic [WIDTH-1:0] dstVal,
  output logic             dstEn
);
  logic [WIDTH-1:0] holdReg;
  logic             loadNow;

  assign loadNow = strobe.passThru | strobe.grab;

  // No reset: contents are established by the user
  always_ff @(posedge clk) begin
    if (loadNow) holdReg <= srcVal;
  end

  always_comb begin
    dstVal = strobe.passThru ? srcVal : holdReg;
    dstEn  = strobe.drive;
  end
endmodule

// File: rtl/xcvrBridge.sv
module xcvrBridge
  import xcvrPkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] aDrv,
  input  logic [WIDTH-1:0] bIn,
  input  logic [WIDTH-1:0] bDrv,
  input  logic             leAb,
  input  logic             cpAb,
  input  logic             ceAbN,
  input  logic             oeAbN,
  input  logic             leBa,
  input  logic             cpBa,
  input  logic             ceBaN,
  input  logic             oeBaN,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn
);
  logic [WIDTH-1:0] aBus;
  logic [WIDTH-1:0] bBus;
  xcvrStrobe_t      strobeAb;
  xcvrStrobe_t      strobeBa;

  xcvrBusKeeper #(.WIDTH(WIDTH)) uKeepA (
    .clk(clk), .rstN(rstN), .padIn(aIn), .padDrv(aDrv), .busVal(aBus)
  );
  xcvrBusKeeper #(.WIDTH(WIDTH)) uKeepB (
    .clk(clk), .rstN(rstN), .padIn(bIn), .padDrv(bDrv), .busVal(bBus)
  );

  xcvrCtrl uCtrlAb (
    .clk(clk), .rstN(rstN), .latchEn(leAb), .clkIn(cpAb),
    .clkEnN(ceAbN), .outEnN(oeAbN), .strobe(strobeAb)
  );
  xcvrCtrl uCtrlBa (
    .clk(clk), .rstN(rstN), .latchEn(leBa), .clkIn(cpBa),
    .clkEnN(ceBaN), .outEnN(oeBaN), .strobe(strobeBa)
  );

  xcvrPath #(.WIDTH(WIDTH)) uPathAb (
    .clk(clk), .srcVal(aBus), .strobe(strobeAb), .dstVal(bOut), .dstEn(bOutEn)
  );
  xcvrPath #(.WIDTH(WIDTH)) uPathBa (
    .clk(clk), .srcVal(bBus), .strobe(strobeBa), .dstVal(aOut), .dstEn(aOutEn)
  );
endmodule

// File: rtl/xcvrBridgeChecker.sv
module xcvrBridgeChecker #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aDrv,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bDrv,
  input logic             leAb,
  input logic             cpAb,
  input logic             ceAbN,
  input logic             leBa,
  input logic             cpBa,
  input logic             ceBaN,
  input logic [WIDTH-1:0] bOut,
  input logic             bOutEn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOutEn
);
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !(aOutEn && bOutEn)); // R6

  AST_AB_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (leAb && (&aDrv)) |-> (bOut == aIn)); // R2
  AST_BA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (leBa && (&bDrv)) |-> (aOut == bIn)); // R2

  AST_AB_CE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!leAb && $past(!leAb) && $past(ceAbN)) |-> $stable(bOut)); // R5
  AST_BA_CE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!leBa && $past(!leBa) && $past(ceBaN)) |-> $stable(aOut)); // R5

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!leAb && !ceAbN && $rose(cpAb) && (&aDrv)) |=> (leAb || bOut == $past(aIn))); // R4
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!leBa && !ceBaN && $rose(cpBa) && (&bDrv)) |=> (leBa || aOut == $past(bIn))); // R4

  AST_AB_KEEPER: assert property (@(posedge clk) disable iff (!rstN)
    (leAb && $past(leAb) && aDrv == '0 && $past(aDrv) == '0) |-> $stable(bOut)); // R8
  AST_BA_KEEPER: assert property (@(posedge clk) disable iff (!rstN)
    (leBa && $past(leBa) && bDrv == '0 && $past(bDrv) == '0) |-> $stable(aOut)); // R8
endmodule

bind xcvrBridge xcvrBridgeChecker #(.WIDTH(WIDTH)) uChecker (
  .clk(clk), .rstN(rstN), .aIn(aIn), .aDrv(aDrv), .bIn(bIn), .bDrv(bDrv),
  .leAb(leAb), .cpAb(cpAb), .ceAbN(ceAbN), .leBa(leBa), .cpBa(cpBa), .ceBaN(ceBaN),
  .bOut(bOut), .bOutEn(bOutEn), .aOut(aOut), .aOutEn(aOutEn)
);

// File: tb/xcvrBridge_test.sv
`timescale 1ns/1ps
module xcvrBridge_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, aDrv = '0, bIn = '0, bDrv = '0;
  logic leAb = 1'b1, cpAb = 1'b0, ceAbN = 1'b0, oeAbN = 1'b0;
  logic leBa = 1'b1, cpBa = 1'b0, ceBaN = 1'b0, oeBaN = 1'b1;
  logic [W-1:0] bOut, aOut;
  logic bOutEn, aOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] mKeepA = '0, mKeepB = '0, mStoreAb = '0, mStoreBa = '0;
  bit mPrevAb = 0, mPrevBa = 0, mValidAb = 0, mValidBa = 0;

  always #10 clk = ~clk;

  xcvrBridge #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aDrv(aDrv), .bIn(bIn), .bDrv(bDrv),
    .leAb(leAb), .cpAb(cpAb), .ceAbN(ceAbN), .oeAbN(oeAbN),
    .leBa(leBa), .cpBa(cpBa), .ceBaN(ceBaN), .oeBaN(oeBaN),
    .bOut(bOut), .bOutEn(bOutEn), .aOut(aOut), .aOutEn(aOutEn)
  );

  function automatic logic [W-1:0] resolve(logic [W-1:0] pin, logic [W-1:0] drv,
                                           logic [W-1:0] keep);
    return (pin & drv) | (keep & ~drv);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model update for one system clock edge, using the inputs present at it
  task automatic modelEdge();
    logic [W-1:0] effA, effB;
    effA = resolve(aIn, aDrv, mKeepA);
    effB = resolve(bIn, bDrv, mKeepB);
    if (leAb || (!ceAbN && cpAb && !mPrevAb)) begin mStoreAb = effA; mValidAb = 1; end
    if (leBa || (!ceBaN && cpBa && !mPrevBa)) begin mStoreBa = effB; mValidBa = 1; end
    if (!rstN) begin
      mKeepA = '0; mKeepB = '0; mPrevAb = 0; mPrevBa = 0;
    end else begin
      mKeepA = effA; mKeepB = effB; mPrevAb = cpAb; mPrevBa = cpBa;
    end
  endtask

  task automatic compareAll(string tag);
    logic [W-1:0] expB, expA;
    expB = leAb ? resolve(aIn, aDrv, mKeepA) : mStoreAb;
    expA = leBa ? resolve(bIn, bDrv, mKeepB) : mStoreBa;
    if (leAb || mValidAb) check({tag, " bOut"}, bOut, expB);
    if (leBa || mValidBa) check({tag, " aOut"}, aOut, expA);
    check({tag, " bOutEn"}, {{(W-1){1'b0}}, bOutEn}, {{(W-1){1'b0}}, ~oeAbN});
    check({tag, " aOutEn"}, {{(W-1){1'b0}}, aOutEn}, {{(W-1){1'b0}}, ~oeBaN});
  endtask

  // One clock: edge, model, compare away from the edge, return at negedge
  task automatic tick(string tag);
    @(posedge clk);
    modelEdge();
    #5;
    compareAll(tag);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    repeat (3) begin @(posedge clk); modelEdge(); @(negedge clk); end
    rstN = 1'b1;
    // R8 reset state: undriven buses read the cleared keepers under pass-through
    tick("R8 reset");
    check("R8 reset literal bOut", bOut, '0);
    check("R8 reset literal aOut", aOut, '0);

    // R2: pass-through while clock and enable move; both directions (R1)
    aDrv = '1; bDrv = '1; oeBaN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      aIn = $urandom; bIn = $urandom; cpAb = i[0]; ceAbN = i[1]; cpBa = ~i[0]; ceBaN = i[0];
      tick("R2 R1 transparent");
    end

    // R7: latch falls, last high-cycle value held
    aIn = 18'h2A5C3; bIn = 18'h15A3C; cpAb = 0; cpBa = 0; ceAbN = 1; ceBaN = 1;
    tick("R7 last open");
    leAb = 0; leBa = 0; aIn = 18'h0F0F0; bIn = 18'h30303;
    tick("R7 closed");
    check("R7 literal bOut", bOut, 18'h2A5C3);
    check("R7 literal aOut", aOut, 18'h15A3C);

    // R3: clock held steady high, enable active, data moving
    ceAbN = 0; ceBaN = 0; cpAb = 1; cpBa = 1;
    tick("R4 rise");
    for (int i = 0; i < 4; i++) begin
      aIn = $urandom; bIn = $urandom;
      tick("R3 steady clock");
    end
    cpAb = 0; cpBa = 0;
    for (int i = 0; i < 3; i++) begin aIn = $urandom; tick("R3 steady low"); end

    // R4: enabled rising sample loads; directions with different data (R1)
    aIn = 18'h3FFFF; bIn = 18'h00001; cpAb = 1; cpBa = 0;
    tick("R4 capture ab");
    check("R4 literal bOut", bOut, 18'h3FFFF);
    bIn = 18'h12345; cpBa = 1; aIn = 18'h00000;
    tick("R4 capture ba");
    check("R4 literal aOut", aOut, 18'h12345);
    check("R1 ab kept", bOut, 18'h3FFFF);

    // R5: edges with enable high are ignored
    ceAbN = 1; ceBaN = 1;
    for (int i = 0; i < 6; i++) begin
      cpAb = i[0]; cpBa = i[0]; aIn = $urandom; bIn = $urandom;
      tick("R5 edges blocked");
    end
    check("R5 literal bOut", bOut, 18'h3FFFF);

    // R6: release B, data kept, enable A side, then swap back
    oeAbN = 1;
    tick("R6 released");
    check("R6 data kept", bOut, 18'h3FFFF);
    oeBaN = 0;
    tick("R6 other enabled");
    oeBaN = 1; oeAbN = 0;
    tick("R6 reenable");
    check("R6 same word", bOut, 18'h3FFFF);

    // R8: partially driven source under pass-through
    leAb = 1; aDrv = '1; aIn = 18'h2AAAA;
    tick("R8 seed");
    aDrv = 18'h000FF; aIn = 18'h15555;
    tick("R8 partial");
    check("R8 literal", bOut, 18'h2AA55);

    // random phase, both directions, no contention
    for (int i = 0; i < 400; i++) begin
      aIn = $urandom; bIn = $urandom;
      aDrv = ($urandom % 4 == 0) ? W'($urandom) : '1;
      bDrv = ($urandom % 4 == 0) ? W'($urandom) : '1;
      leAb = ($urandom % 4 == 0); leBa = ($urandom % 4 == 0);
      cpAb = $urandom; cpBa = $urandom;
      ceAbN = ($urandom % 3 == 0); ceBaN = ($urandom % 3 == 0);
      oeAbN = $urandom; oeBaN = $urandom;
      if (!oeAbN && !oeBaN) oeBaN = 1;
      tick("R1 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule